// File: doc/BRIEF.md
# Expression Evaluation Stack with Cached Top

This block is the operand stack of a stack-oriented byte-code processor. Loads and immediates are pushed onto it. Stores pop values from it. Arithmetic and Boolean operations take their two operands from the top two entries and leave a single result in their place. No instruction names a register, so the stack alone decides where each operand sits.

The topmost value lives in a dedicated register that drives the result output directly. The entries below it sit in a small register file indexed by the entry count. Because of this split, a binary operation reads only one entry from the file, and each command writes at most one entry. Every accepted command stores the current top into the slot just above the entries still live beneath it. As a result, a value that has just been popped or consumed stays in the file. A recover command brings such a value back by moving only the pointer. Recover is allowed only up to the deepest level reached since reset.

A 32-bit quantity is held as two consecutive 16-bit entries, pushed and popped as a pair in last-in, first-out order.

Top module: `expr_stack`

## Requirements
- R1: After reset, `tos` is 0, both flags are 0 and the stack holds no entries, so a following pop flags underflow.
- R2: A push (cmd 1) of a non-full stack shows `din` on `tos` after the clock edge, and the previous top becomes the entry beneath it.
- R3: A push while DEPTH entries are held raises `overflow` for exactly the following cycle and changes neither `tos` nor the stored entries.
- R4: A pop (cmd 2) removes the top, and `tos` then shows the entry beneath it. A pop that empties the stack leaves `tos` unchanged. A pop of an empty stack raises `underflow` for one cycle and has no other effect.
- R5: Binary commands combine the entry beneath the top (N) with the top (T) and leave one result: cmd 3 gives N+T modulo 2^16, cmd 4 gives N-T, cmd 5 gives N AND T, cmd 6 gives N OR T and cmd 7 gives N XOR T. The entry count falls by one.
- R6: A binary command with fewer than two entries raises `underflow` for one cycle and leaves `tos` and the stack unchanged.
- R7: Recover (cmd 8) raises the count by one and shows on `tos` the value that last occupied that level. After a pop, this is the popped value. After a binary command, it is the former top operand.
- R8: Recover when the count already equals the highest count reached since reset raises `underflow` for one cycle and changes nothing.
- R9: Command 0 and all unassigned codes (9 to 15) leave `tos` and the stack unchanged and raise no flag.
- R10: Entries leave in reverse order of entry across the full depth. A 32-bit value pushed low half first then high half returns high half first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 4 | Command code applied this cycle |
| din | input | WIDTH | Value to push |
| tos | output | WIDTH | Current top-of-stack value |
| overflow | output | 1 | Push was rejected on the previous edge |
| underflow | output | 1 | Pop, binary command or recover was rejected on the previous edge |

## Verification
The assertions assume that `cmd` and `din` are settled before each rising edge and are meaningful on every cycle. Any code outside the defined set is taken to mean no operation, so no input value is illegal. The stimulus changes inputs only shortly after an edge and holds each command for exactly one cycle. It deliberately issues every rejected case, so the flag and hold properties are exercised as well as the accepting paths.

// File: rtl/expr_stack_pkg.sv
package expr_stack_pkg;
  typedef enum logic [3:0] {
    CMD_NOP     = 4'd0,
    CMD_PUSH    = 4'd1,
    CMD_POP     = 4'd2,
    CMD_ADD     = 4'd3,
    CMD_SUB     = 4'd4,
    CMD_AND     = 4'd5,
    CMD_OR      = 4'd6,
    CMD_XOR     = 4'd7,
    CMD_RECOVER = 4'd8
  } cmd_e;

  function automatic logic cmd_is_binary(input logic [3:0] c);
    return (c >= CMD_ADD) && (c <= CMD_XOR);
  endfunction
endpackage

// File: rtl/stack_regfile.sv
module stack_regfile #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_addr == AW'(i))) slot[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (rd_addr == AW'(j)) rd_data = slot[j];
    end
  end
endmodule

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import expr_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    cmd,
  output logic          ev_push,
  output logic          ev_pop,
  output logic          ev_bin,
  output logic          ev_rec,
  output logic          ev_reject,
  output logic          keep_top,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          overflow,
  output logic          underflow
);
  logic [CW-1:0] cnt, hwm;
  logic is_push, is_pop, is_bin, is_rec;
  logic ovf_ev, unf_ev;

  assign is_push = (cmd == CMD_PUSH);
  assign is_pop  = (cmd == CMD_POP);
  assign is_bin  = cmd_is_binary(cmd);
  assign is_rec  = (cmd == CMD_RECOVER);

  assign ovf_ev = is_push && (cnt == CW'(DEPTH));
  assign unf_ev = (is_pop && (cnt == '0)) ||
                  (is_bin && (cnt < CW'(2))) ||
                  (is_rec && (cnt >= hwm));

  assign ev_push   = is_push && !ovf_ev;
  assign ev_pop    = is_pop  && !unf_ev;
  assign ev_bin    = is_bin  && !unf_ev;
  assign ev_rec    = is_rec  && !unf_ev;
  assign ev_reject = ovf_ev || unf_ev;
  assign keep_top  = ev_pop && (cnt == CW'(1));

  // Every accepted command parks the current top in the slot above the live entries.
  assign wr_en   = (ev_push || ev_pop || ev_bin || ev_rec) && (cnt != '0);
  assign wr_addr = AW'(cnt - CW'(1));
  assign rd_addr = ev_rec ? AW'(cnt) : AW'(cnt - CW'(2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      hwm       <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      overflow  <= ovf_ev;
      underflow <= unf_ev;
      if (ev_push || ev_rec) cnt <= cnt + CW'(1);
      else if (ev_pop || ev_bin) cnt <= cnt - CW'(1);
      if (ev_push && ((cnt + CW'(1)) > hwm)) hwm <= cnt + CW'(1);
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_recover_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= hwm);
  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(overflow && underflow));
  assert_reject_holds_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> $stable(cnt));
  assert_one_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_push, ev_pop, ev_bin, ev_rec, ev_reject}));
endmodule

// File: rtl/expr_stack.sv
module expr_stack
  import expr_stack_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       cmd,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] tos,
  output logic             overflow,
  output logic             underflow
);
  logic ev_push, ev_pop, ev_bin, ev_rec, ev_reject, keep_top, wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [WIDTH-1:0] rd_data, tos_q;

  function automatic logic [WIDTH-1:0] alu_eval(input logic [3:0] op,
                                                input logic [WIDTH-1:0] nos,
                                                input logic [WIDTH-1:0] top);
    case (op)
      CMD_ADD: return nos + top;
      CMD_SUB: return nos - top;
      CMD_AND: return nos & top;
      CMD_OR:  return nos | top;
      CMD_XOR: return nos ^ top;
      default: return top;
    endcase
  endfunction

  stack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd(cmd),
    .ev_push(ev_push), .ev_pop(ev_pop), .ev_bin(ev_bin), .ev_rec(ev_rec),
    .ev_reject(ev_reject), .keep_top(keep_top),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .overflow(overflow), .underflow(underflow)
  );

  stack_regfile #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_file (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(tos_q),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) tos_q <= '0;
    else if (ev_push) tos_q <= din;
    else if (ev_pop && !keep_top) tos_q <= rd_data;
    else if (ev_bin) tos_q <= alu_eval(cmd, rd_data, tos_q);
    else if (ev_rec) tos_q <= rd_data;
  end

  assign tos = tos_q;

  assert_push_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |=> (tos == $past(din)));
  assert_reject_keeps_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> $stable(tos));
  assert_idle_keeps_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_push || ev_pop || ev_bin || ev_rec) |=> $stable(tos));
  assert_flag_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> (overflow || underflow));
endmodule

// File: tb/expr_stack_test.sv
module expr_stack_test;
  localparam int W = 16;
  localparam int D = 8;
  localparam logic [3:0] C_NOP = 4'd0, C_PUSH = 4'd1, C_POP = 4'd2, C_ADD = 4'd3,
                         C_SUB = 4'd4, C_AND = 4'd5, C_OR = 4'd6, C_XOR = 4'd7,
                         C_REC = 4'd8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] cmd = C_NOP;
  logic [W-1:0] din = '0;
  logic [W-1:0] tos;
  logic overflow, underflow;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference: plain array indexed by a count, stale values left in place
  logic [W-1:0] arr [D];
  int n, hw;
  logic [W-1:0] etop;

  expr_stack #(.WIDTH(W), .DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .din(din),
    .tos(tos), .overflow(overflow), .underflow(underflow)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    cmd = C_NOP;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    n = 0; hw = 0; etop = '0;
  endtask

  task automatic step(input string req, input logic [3:0] c, input logic [W-1:0] d);
    logic eo, eu;
    eo = 0; eu = 0;
    cmd = c; din = d;
    @(posedge clk);
    #2;
    case (c)
      C_PUSH: if (n == D) eo = 1;
              else begin arr[n] = d; n++; etop = d; if (n > hw) hw = n; end
      C_POP:  if (n == 0) eu = 1;
              else begin n--; if (n > 0) etop = arr[n-1]; end
      C_ADD, C_SUB, C_AND, C_OR, C_XOR:
              if (n < 2) eu = 1;
              else begin
                logic [W-1:0] a, b;
                a = arr[n-2]; b = arr[n-1];
                case (c)
                  C_ADD: arr[n-2] = W'(a + b);
                  C_SUB: arr[n-2] = W'(a - b);
                  C_AND: arr[n-2] = a & b;
                  C_OR:  arr[n-2] = a | b;
                  default: arr[n-2] = a ^ b;
                endcase
                n--; etop = arr[n-1];
              end
      C_REC:  if (n >= hw) eu = 1;
              else begin n++; etop = arr[n-1]; end
      default: ;
    endcase
    check(req, "tos", tos, etop);
    check(req, "overflow", W'(overflow), W'(eo));
    check(req, "underflow", W'(underflow), W'(eu));
    cmd = C_NOP;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check("R1", "tos after reset", tos, '0);
    check("R1", "overflow after reset", W'(overflow), '0);
    check("R1", "underflow after reset", W'(underflow), '0);
    step("R1", C_POP, '0);
  endtask

  task automatic t_push_pop();
    do_reset();
    step("R2", C_PUSH, 16'h1111);
    step("R2", C_PUSH, 16'h2222);
    step("R2", C_PUSH, 16'h3333);
    step("R4", C_POP, '0);
    check("R4", "tos after pop", tos, 16'h2222);
    step("R4", C_POP, '0);
    step("R4", C_POP, '0);
    check("R4", "tos kept on emptying pop", tos, 16'h1111);
    step("R4", C_POP, '0);
  endtask

  task automatic t_alu();
    do_reset();
    step("R5", C_PUSH, 16'd10);
    step("R5", C_PUSH, 16'd3);
    step("R5", C_SUB, '0);
    check("R5", "sub", tos, 16'd7);
    step("R5", C_PUSH, 16'hFFFF);
    step("R5", C_PUSH, 16'h0002);
    step("R5", C_ADD, '0);
    check("R5", "add wrap", tos, 16'h0001);
    step("R5", C_PUSH, 16'hF0F0);
    step("R5", C_AND, '0);
    step("R5", C_PUSH, 16'h0FF0);
    step("R5", C_OR, '0);
    step("R5", C_PUSH, 16'h5A5A);
    step("R5", C_XOR, '0);
    step("R5", C_ADD, '0);
    check("R5", "chain", tos, W'(16'd7 + ((16'h0000 | 16'h0FF0) ^ 16'h5A5A)));
  endtask

  task automatic t_bin_under();
    do_reset();
    step("R6", C_ADD, '0);
    step("R6", C_PUSH, 16'h0005);
    step("R6", C_XOR, '0);
    check("R6", "tos held", tos, 16'h0005);
    step("R6", C_POP, '0);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < D; i++) step("R10", C_PUSH, W'(16'hA000 + i));
    step("R3", C_PUSH, 16'hBEEF);
    check("R3", "tos after rejected push", tos, W'(16'hA000 + D - 1));
    for (int i = 0; i < D - 1; i++) step("R10", C_POP, '0);
    check("R10", "bottom entry", tos, 16'hA000);
    do_reset();
    step("R10", C_PUSH, 16'h5678);
    step("R10", C_PUSH, 16'h1234);
    check("R10", "high half on top", tos, 16'h1234);
    step("R10", C_POP, '0);
    check("R10", "low half next", tos, 16'h5678);
  endtask

  task automatic t_recover();
    do_reset();
    step("R7", C_PUSH, 16'h00AA);
    step("R7", C_PUSH, 16'h00BB);
    step("R7", C_PUSH, 16'h00CC);
    step("R7", C_POP, '0);
    step("R7", C_REC, '0);
    check("R7", "popped value back", tos, 16'h00CC);
    step("R7", C_ADD, '0);
    step("R7", C_REC, '0);
    check("R7", "former operand back", tos, 16'h00CC);
    step("R7", C_POP, '0);
    check("R7", "sum below", tos, 16'h0187);
  endtask

  task automatic t_recover_limit();
    do_reset();
    step("R8", C_PUSH, 16'h0101);
    step("R8", C_PUSH, 16'h0202);
    step("R8", C_REC, '0);
    step("R8", C_POP, '0);
    step("R8", C_POP, '0);
    step("R8", C_REC, '0);
    check("R8", "first recover", tos, 16'h0101);
    step("R8", C_REC, '0);
    check("R8", "second recover", tos, 16'h0202);
    step("R8", C_REC, '0);
  endtask

  task automatic t_nop();
    do_reset();
    step("R9", C_PUSH, 16'h7777);
    step("R9", C_NOP, 16'h1234);
    step("R9", 4'd9, 16'h1111);
    step("R9", 4'd15, 16'h2222);
    step("R9", 4'd12, 16'h3333);
    step("R9", C_POP, '0);
    step("R9", C_POP, '0);
  endtask

  initial begin
    t_reset();
    t_push_pop();
    t_alu();
    t_bin_under();
    t_overflow();
    t_recover();
    t_recover_limit();
    t_nop();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule